// File: doc/BRIEF.md
# Acquisition Timeout Supervisor

This block watches one sampling transaction spread across two serial receive lines. A trigger pulse opens the transaction. Each line is then expected to show a falling edge, which opens a burst of four byte packets. After that, a receiver stub reports the start bit of each later packet. The block bounds both waits with limits that software programs: one limit from the trigger to the first edge, and one limit from each packet to the next start bit.

When a wait runs out, that line gives up. The packets it never received are added to a saturating failure counter. The transaction still completes, so an upstream scheduler waiting on the done pulse is never stalled by a broken or unplugged data line.

Top module: `acq_timeout_guard`

## Requirements
- R1: A trigger while idle starts a transaction. When every line receives its falling edge and then three start bits, each start bit arriving no later than `gap_limit`+1 cycles after the previous event, `acq_done` pulses in the cycle after the last event edge and `fail_count` does not change.
- R2: The first-edge wait has a boundary. A falling edge seen at trigger edge + k, with k ≤ `fe_limit`+1, is accepted. If no edge arrives, the line times out at trigger edge + `fe_limit`+1 and adds 4 to `fail_count`.
- R3: A start bit missing for `gap_limit`+1 cycles after the previous event ends that line. The line adds 4 minus the packets it received.
- R4: A limit input of 0 selects the default: 2000 cycles for the first edge and 500 cycles for the gap.
- R5: Both limits are captured on the accepted trigger. Later changes to the limit inputs do not affect the running transaction.
- R6: Each line keeps its own timer and packet count. One line can time out while the other delivers all its packets.
- R7: `acq_done` is high for exactly one cycle per transaction. It rises only once every line has either finished or timed out.
- R8: A trigger that arrives while a transaction is running is ignored. It produces no second done pulse.
- R9: `fail_count` is 16 bits wide and saturates at 65535.
- R10: `fail_clr` zeroes `fail_count` on the next edge. It takes priority over any increment on that same edge.
- R11: `rst_n` is an asynchronous active-low reset. It forces `fail_count` to 0 and `acq_done` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trigger | input | 1 | Sample trigger pulse |
| fe_limit | input | 16 | Trigger-to-first-edge limit in cycles; 0 selects 2000 |
| gap_limit | input | 16 | Packet-to-next-start-bit limit in cycles; 0 selects 500 |
| line_rx | input | 2 | Serial data lines, idle high |
| start_bit | input | 2 | Per-line pulse from the receiver stub marking a later packet's start bit |
| fail_clr | input | 1 | Clears the failure counter |
| acq_done | output | 1 | One-cycle transaction-complete pulse |
| fail_count | output | 16 | Saturating count of missed packets |

## Verification
Every result is tied to a clock edge counted from the edge that accepts the trigger:
- A line finishes on the edge of its last accepted event, or on edge `limit`+1 of a silent wait.
- The done pulse and the updated failure count are both visible right after the latest line finishes.

The driver works out that edge number and the expected count, then pushes them into a queue. The monitor samples on the falling clock edge. Each time it sees `acq_done`, it pops one entry and compares both the cycle number and the count. An unexpected pulse counts as a failure, and so does an entry left in the queue.

// File: rtl/acq_timeout_guard.sv
module acq_timeout_guard #(
  parameter int NLINE   = 2,
  parameter int NPKT    = 4,
  parameter int LIM_W   = 16,
  parameter int FE_DEF  = 2000,
  parameter int GAP_DEF = 500,
  parameter int FAIL_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trigger,
  input  logic [LIM_W-1:0]  fe_limit,
  input  logic [LIM_W-1:0]  gap_limit,
  input  logic [NLINE-1:0]  line_rx,
  input  logic [NLINE-1:0]  start_bit,
  input  logic              fail_clr,
  output logic              acq_done,
  output logic [FAIL_W-1:0] fail_count
);
  localparam int PW    = $clog2(NPKT + 1);
  localparam int SUM_W = FAIL_W + $clog2(NLINE * NPKT + 1);

  typedef enum logic [1:0] {S_IDLE, S_WFE, S_WSB, S_END} lane_t;

  lane_t             st   [NLINE];
  logic [LIM_W-1:0]  tmr  [NLINE];
  logic [PW-1:0]     got  [NLINE];
  logic [PW-1:0]     miss [NLINE];
  logic [NLINE-1:0]  rx_q, fe, to, ended;
  logic [LIM_W-1:0]  fe_lim_q, gap_lim_q;
  logic [SUM_W-1:0]  sum;
  logic              busy, start;

  assign start    = trigger & ~busy;
  assign acq_done = busy & (&ended);

  always_comb begin
    sum = SUM_W'(fail_count);
    for (int i = 0; i < NLINE; i++) begin
      fe[i]    = rx_q[i] & ~line_rx[i];
      ended[i] = (st[i] == S_END);
      to[i]    = (st[i] == S_WFE && !fe[i] && tmr[i] == fe_lim_q) ||
                 (st[i] == S_WSB && !start_bit[i] && tmr[i] == gap_lim_q);
      miss[i]  = !to[i] ? '0 : (st[i] == S_WFE) ? PW'(NPKT) : PW'(NPKT) - got[i];
      sum      = sum + SUM_W'(miss[i]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      fe_lim_q   <= LIM_W'(FE_DEF);
      gap_lim_q  <= LIM_W'(GAP_DEF);
      fail_count <= '0;
    end else begin
      if (start) begin
        busy      <= 1'b1;
        fe_lim_q  <= (fe_limit == '0)  ? LIM_W'(FE_DEF)  : fe_limit;
        gap_lim_q <= (gap_limit == '0) ? LIM_W'(GAP_DEF) : gap_limit;
      end else if (acq_done) begin
        busy <= 1'b0;
      end
      if (fail_clr)
        fail_count <= '0;
      else if (sum > SUM_W'({FAIL_W{1'b1}}))
        fail_count <= '1;
      else
        fail_count <= sum[FAIL_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_q <= '1;
      for (int i = 0; i < NLINE; i++) begin
        st[i]  <= S_IDLE;
        tmr[i] <= '0;
        got[i] <= '0;
      end
    end else begin
      rx_q <= line_rx;
      for (int i = 0; i < NLINE; i++) begin
        if (start) begin
          st[i]  <= S_WFE;
          tmr[i] <= '0;
          got[i] <= '0;
        end else if (acq_done) begin
          st[i] <= S_IDLE;
        end else begin
          case (st[i])
            S_WFE: begin
              if (fe[i]) begin
                got[i] <= PW'(1);
                tmr[i] <= '0;
                st[i]  <= (NPKT == 1) ? S_END : S_WSB;
              end else if (to[i]) begin
                st[i] <= S_END;
              end else if (tmr[i] != '1) begin
                tmr[i] <= tmr[i] + 1'b1;
              end
            end
            S_WSB: begin
              if (start_bit[i]) begin
                got[i] <= got[i] + 1'b1;
                tmr[i] <= '0;
                if (got[i] + 1'b1 == PW'(NPKT)) st[i] <= S_END;
              end else if (to[i]) begin
                st[i] <= S_END;
              end else if (tmr[i] != '1) begin
                tmr[i] <= tmr[i] + 1'b1;
              end
            end
            default: ;
          endcase
        end
      end
    end
  end
endmodule

module acq_timeout_guard_chk #(
  parameter int NLINE  = 2,
  parameter int NPKT   = 4,
  parameter int FAIL_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              trigger,
  input logic              busy,
  input logic              acq_done,
  input logic              fail_clr,
  input logic [FAIL_W-1:0] fail_count
);
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    acq_done |=> !acq_done);
  a_r7_done_in_txn: assert property (@(posedge clk) disable iff (!rst_n)
    acq_done |-> busy);
  a_r1_start_needs_trigger: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(trigger));
  a_r8_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !acq_done) |=> busy);
  a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
    fail_clr |=> fail_count == '0);
  a_r9_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
    !fail_clr |=> fail_count >= $past(fail_count));
  a_r3_step_bound: assert property (@(posedge clk) disable iff (!rst_n)
    !fail_clr |=> (fail_count - $past(fail_count)) <= FAIL_W'(NLINE * NPKT));
endmodule

bind acq_timeout_guard acq_timeout_guard_chk #(.NLINE(NLINE), .NPKT(NPKT), .FAIL_W(FAIL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .trigger(trigger), .busy(busy),
  .acq_done(acq_done), .fail_clr(fail_clr), .fail_count(fail_count)
);

// File: tb/acq_timeout_guard_bench.sv
module acq_timeout_guard_bench;
  logic        clk = 0, rst_n = 0, trigger = 0, fail_clr = 0;
  logic [15:0] fe_limit = 0, gap_limit = 0, fail_count;
  logic [1:0]  line_rx = 2'b11, start_bit = 0;
  logic        acq_done;

  acq_timeout_guard u_acq_timeout_guard (
    .clk(clk), .rst_n(rst_n), .trigger(trigger), .fe_limit(fe_limit),
    .gap_limit(gap_limit), .line_rx(line_rx), .start_bit(start_bit),
    .fail_clr(fail_clr), .acq_done(acq_done), .fail_count(fail_count)
  );

  always #5 clk = ~clk;

  int    cyc = 0, checks = 0, fails = 0, model = 0;
  int    q_cyc[$], q_fail[$];
  string q_tag[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && acq_done) begin
      if (q_cyc.size() == 0) begin
        check(0, "R8 unexpected done", cyc, -1);
      end else begin
        automatic int    ec = q_cyc.pop_front();
        automatic int    ef = q_fail.pop_front();
        automatic string t  = q_tag.pop_front();
        check(cyc == ec, {t, " done cycle"}, cyc, ec);
        check(int'(fail_count) == ef, {t, " fail_count"}, fail_count, ef);
      end
    end
  end

  function automatic int line_end(input int fe, n, sp, fel, gl, output int miss);
    if (fe < 0) begin miss = 4; return fel + 1; end
    if (n >= 3) begin miss = 0; return fe + 3 * sp; end
    miss = 3 - n;
    return fe + n * sp + gl + 1;
  endfunction

  task automatic txn(input string tag, input int fel, gl, feA, nA, feB, nB, sp, clr_at);
    int efel, egl, mA, mB, eA, eB, last, T;
    efel = (fel == 0) ? 2000 : fel;
    egl  = (gl == 0) ? 500 : gl;
    eA   = line_end(feA, nA, sp, efel, egl, mA);
    eB   = line_end(feB, nB, sp, efel, egl, mB);
    last = (eA > eB) ? eA : eB;
    @(negedge clk);
    T = cyc + 1;
    model = (clr_at > 0) ? 0 : ((model + mA + mB > 65535) ? 65535 : model + mA + mB);
    q_cyc.push_back(T + last); q_fail.push_back(model); q_tag.push_back(tag);
    trigger = 1; fe_limit = 16'(fel); gap_limit = 16'(gl);
    for (int rel = 1; rel <= last + 3; rel++) begin
      @(negedge clk);
      trigger   = (rel == 2);
      fe_limit  = 16'd1;
      gap_limit = 16'd1;
      fail_clr  = (rel == clr_at);
      line_rx[0] = !(rel == feA);
      line_rx[1] = !(rel == feB);
      start_bit[0] = feA > 0 && rel > feA && (rel - feA) % sp == 0 && (rel - feA) / sp <= nA;
      start_bit[1] = feB > 0 && rel > feB && (rel - feB) % sp == 0 && (rel - feB) / sp <= nB;
    end
    @(negedge clk);
    trigger = 0; fail_clr = 0; line_rx = 2'b11; start_bit = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 200000);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(fail_count == 0, "R11 reset fail_count", fail_count, 0);
    check(acq_done == 0, "R11 reset done", acq_done, 0);
    rst_n = 1;
    txn("R1 full delivery", 100, 50, 5, 3, 8, 3, 4, 0);
    txn("R2 first-edge timeout", 10, 20, -1, 0, -1, 0, 1, 0);
    txn("R6 independent lines", 30, 20, 3, 3, -1, 0, 5, 0);
    txn("R3 gap timeout", 50, 6, 4, 1, 2, 3, 3, 0);
    txn("R3 gap boundary", 50, 6, 2, 3, 2, 3, 7, 0);
    txn("R2 edge boundary", 5, 20, 6, 3, -1, 0, 2, 0);
    txn("R4 default first-edge", 0, 20, -1, 0, -1, 0, 1, 0);
    txn("R4 default gap", 400, 0, 2, 0, 3, 3, 100, 0);
    txn("R5 limits latched", 200, 80, 150, 3, 120, 3, 60, 0);
    txn("R10 clear beats timeout", 4, 4, -1, 0, -1, 0, 1, 5);
    txn("R2 restart after clear", 3, 4, -1, 0, -1, 0, 1, 0);
    @(negedge clk); fail_clr = 1;
    @(negedge clk); fail_clr = 0; model = 0;
    check(fail_count == 0, "R10 standalone clear", fail_count, 0);
    for (int k = 0; k < 8200; k++) txn("R9 saturation", 1, 1, -1, 0, -1, 0, 1, 0);
    check(fail_count == 16'hFFFF, "R9 saturated value", fail_count, 65535);
    @(negedge clk); rst_n = 0;
    #1;
    check(fail_count == 0, "R11 async reset", fail_count, 0);
    @(negedge clk); rst_n = 1; model = 0;
    txn("R1 after reset", 60, 30, 2, 3, 4, 3, 3, 0);
    repeat (10) @(negedge clk);
    check(q_cyc.size() == 0, "R7 all done pulses seen", q_cyc.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule